// File: doc/BRIEF.md
# Memory-Reference Instruction Decoder

This block is the purely combinational front end of an execution unit for a 12-bit accumulator machine whose instruction fields are laid out in octal. Each cycle it takes the instruction word that was fetched, the 15-bit address that word was fetched from, and the 6-bit field buffer. The address is a 3-bit field number above a 12-bit offset. The buffer holds a 3-bit data field above a 3-bit instruction field.

From these inputs it produces several results:
- the opcode class;
- the set of control requests the sequencer must honour: operand load, operand store, accumulator read and write, link read and write, possible change of flow, pointer fetch and pointer increment;
- the default successor address;
- the formed 15-bit operand address.

When the pointer-fetch request is raised, the formed address is the location of a pointer and not the operand itself. The operate and I/O-transfer groups are only recognised and flagged as unimplemented. Sequencing and memory access belong to the stages around this block.

Top module: `mri_decoder`

## Requirements
- R1: `op_class` equals instruction bits 11:9, encoded 0 AND, 1 TAD, 2 ISZ, 3 DCA, 4 JMS, 5 JMP, 6 IOT, 7 OPR.
- R2: The request flags are set per opcode as follows, with all other flags clear. AND: load, acc_rd, acc_wr. TAD: load, acc_rd, acc_wr, link_rd, link_wr. ISZ: load, store, may_redirect. DCA: store, acc_rd, acc_wr. JMS: store, may_redirect. JMP: may_redirect only.
- R3: For opcodes 6 and 7, `unimpl` is 1. All request flags, `ind_load`, `autoinc_store` and `addr_valid` are 0, and `eff_addr` is 0. For opcodes 0 to 5, `unimpl` is 0.
- R4: `next_pc[14:12]` equals `pc[14:12]`, and `next_pc[11:0]` equals `pc[11:0]` plus one modulo 4096, for every opcode.
- R5: When instruction bit 7 is 0, `eff_addr[11:7]` is 0. When it is 1, `eff_addr[11:7]` equals `pc[11:7]`, the page of the word being decoded and not of its successor. `eff_addr[6:0]` always equals instruction bits 6:0.
- R6: `eff_addr[14:12]` equals `field_buf[5:3]`, the data field, whenever `addr_valid` is 1.
- R7: `addr_valid` is 1 exactly for opcodes 0 to 5.
- R8: `ind_load` equals `addr_valid` AND instruction bit 8. When `ind_load` is 1, `eff_addr` is the pointer location. Otherwise `eff_addr` is the final operand address.
- R9: `autoinc_store` is 1 exactly when all three conditions hold: `ind_load` is 1, the opcode is AND, TAD or DCA (not one of the opcodes that may redirect), and instruction bits 6:3 equal 0001. Bit 7 does not take part.
- R10: `inst_field` equals `field_buf[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 12 | Instruction word being decoded |
| pc | input | 15 | Field and offset the word was fetched from |
| field_buf | input | 6 | Data field in bits 5:3, instruction field in bits 2:0 |
| op_class | output | 3 | Opcode class, instruction bits 11:9 |
| mem_load | output | 1 | Operand load requested |
| mem_store | output | 1 | Operand store requested |
| acc_rd | output | 1 | Accumulator read requested |
| acc_wr | output | 1 | Accumulator write requested |
| link_rd | output | 1 | Link read requested |
| link_wr | output | 1 | Link write requested |
| may_redirect | output | 1 | Instruction may replace the successor address |
| ind_load | output | 1 | Pointer fetch from eff_addr requested |
| autoinc_store | output | 1 | Incremented pointer write-back requested |
| unimpl | output | 1 | Operate or I/O-transfer group seen |
| addr_valid | output | 1 | eff_addr carries a formed address |
| eff_addr | output | 15 | Final operand address or pointer location |
| next_pc | output | 15 | Default successor address |
| inst_field | output | 3 | Instruction field for jump targets |

## Verification
Every result of this block is due in the same cycle as its stimulus, with no register between input and output. The bench therefore drives a new instruction word, address and buffer just after a falling clock edge. It samples all outputs a few nanoseconds later, still before the next rising edge, so each result is read after it has settled. Each result is read before the inputs move again.

Random vectors come from a fixed seed. Directed vectors pin down the cases that random stimulus rarely hits: an offset wrap at 07777, a current-page reference from the last word of a page, the two ends of the 010–017 pointer window, and an indirect ISZ that must not request an increment.

// File: rtl/mri_pkg.sv
package mri_pkg;

  typedef enum logic [2:0] {
    OPC_AND = 3'd0,
    OPC_TAD = 3'd1,
    OPC_ISZ = 3'd2,
    OPC_DCA = 3'd3,
    OPC_JMS = 3'd4,
    OPC_JMP = 3'd5,
    OPC_IOT = 3'd6,
    OPC_OPR = 3'd7
  } opc_e;

  typedef struct packed {
    logic load;
    logic store;
    logic acc_rd;
    logic acc_wr;
    logic link_rd;
    logic link_wr;
    logic redirect;
  } req_flags_t;

  localparam req_flags_t REQ_NONE = '{default: 1'b0};

endpackage

// File: rtl/mri_opc_table.sv
module mri_opc_table
  import mri_pkg::*;
(
  input  logic [2:0]  opc_bits,
  output opc_e        opc,
  output req_flags_t  req,
  output logic        addr_use,
  output logic        unimpl
);

  always_comb begin
    opc      = opc_e'(opc_bits);
    req      = REQ_NONE;
    addr_use = 1'b1;
    unimpl   = 1'b0;
    unique case (opc)
      OPC_AND: begin
        req.load   = 1'b1;
        req.acc_rd = 1'b1;
        req.acc_wr = 1'b1;
      end
      OPC_TAD: begin
        req.load    = 1'b1;
        req.acc_rd  = 1'b1;
        req.acc_wr  = 1'b1;
        req.link_rd = 1'b1;
        req.link_wr = 1'b1;
      end
      OPC_ISZ: begin
        req.load     = 1'b1;
        req.store    = 1'b1;
        req.redirect = 1'b1;
      end
      OPC_DCA: begin
        req.store  = 1'b1;
        req.acc_rd = 1'b1;
        req.acc_wr = 1'b1;
      end
      OPC_JMS: begin
        req.store    = 1'b1;
        req.redirect = 1'b1;
      end
      OPC_JMP: begin
        req.redirect = 1'b1;
      end
      default: begin
        addr_use = 1'b0;
        unimpl   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/mri_pc_step.sv
module mri_pc_step #(
  parameter int OFF_W = 12,
  parameter int FLD_W = 3,
  localparam int ADDR_W = FLD_W + OFF_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] next_pc
);

  // Offset steps with wrap; the field number is carried unchanged.
  function automatic logic [ADDR_W-1:0] step_in_field(input logic [ADDR_W-1:0] a);
    logic [OFF_W-1:0] off;
    off = a[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1};
    return {a[ADDR_W-1:OFF_W], off};
  endfunction

  assign next_pc = step_in_field(pc);

endmodule

// File: rtl/mri_addr_gen.sv
module mri_addr_gen #(
  parameter int OFF_W  = 12,
  parameter int FLD_W  = 3,
  parameter int PAGE_W = 7,
  localparam int ADDR_W = FLD_W + OFF_W,
  localparam int PG_W   = OFF_W - PAGE_W,
  localparam int LO_W   = PAGE_W + 2,
  localparam int AI_W   = PAGE_W - 3
) (
  input  logic [LO_W-1:0]   instr_lo,
  input  logic [PG_W-1:0]   pc_page,
  input  logic [FLD_W-1:0]  data_field,
  input  logic              addr_use,
  input  logic              redirect,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              addr_valid,
  output logic              ind_load,
  output logic              autoinc
);

  logic              page_sel;
  logic              ind_bit;
  logic [PAGE_W-1:0] in_page;
  logic [PG_W-1:0]   page_bits;
  logic [ADDR_W-1:0] formed;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [FLD_W-1:0]  fld,
    input logic [PG_W-1:0]   pg,
    input logic [PAGE_W-1:0] off
  );
    return {fld, pg, off};
  endfunction

  function automatic logic in_ai_window(input logic [PAGE_W-1:0] off);
    return off[PAGE_W-1:3] == AI_W'(1);
  endfunction

  assign page_sel  = instr_lo[PAGE_W];
  assign ind_bit   = instr_lo[PAGE_W+1];
  assign in_page   = instr_lo[PAGE_W-1:0];
  assign page_bits = page_sel ? pc_page : '0;
  assign formed    = form_addr(data_field, page_bits, in_page);

  assign addr_valid = addr_use;
  assign eff_addr   = addr_use ? formed : '0;
  assign ind_load   = addr_use & ind_bit;
  assign autoinc    = ind_load & ~redirect & in_ai_window(in_page);

endmodule

// File: rtl/mri_decoder.sv
module mri_decoder
  import mri_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int FLD_W  = 3,
  parameter int PAGE_W = 7,
  parameter bit PAGE_FROM_NEXT = 1'b0,
  localparam int ADDR_W = FLD_W + OFF_W,
  localparam int BUF_W  = 2 * FLD_W,
  localparam int PG_W   = OFF_W - PAGE_W,
  localparam int LO_W   = PAGE_W + 2
) (
  input  logic [OFF_W-1:0]  instr_word,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BUF_W-1:0]  field_buf,
  output logic [2:0]        op_class,
  output logic              mem_load,
  output logic              mem_store,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic              link_rd,
  output logic              link_wr,
  output logic              may_redirect,
  output logic              ind_load,
  output logic              autoinc_store,
  output logic              unimpl,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] next_pc,
  output logic [FLD_W-1:0]  inst_field
);

  opc_e              opc;
  req_flags_t        req;
  logic              addr_use;
  logic [FLD_W-1:0]  data_field;
  logic [PG_W-1:0]   pc_page;

  assign data_field = field_buf[BUF_W-1:FLD_W];
  assign inst_field = field_buf[FLD_W-1:0];

  mri_opc_table u_opc (
    .opc_bits (instr_word[OFF_W-1:OFF_W-3]),
    .opc      (opc),
    .req      (req),
    .addr_use (addr_use),
    .unimpl   (unimpl)
  );

  mri_pc_step #(.OFF_W(OFF_W), .FLD_W(FLD_W)) u_step (
    .pc      (pc),
    .next_pc (next_pc)
  );

  // Page source: the decoded word's own address, or its successor.
  generate
    if (PAGE_FROM_NEXT) begin : g_page_next
      assign pc_page = next_pc[OFF_W-1:PAGE_W];
    end else begin : g_page_here
      assign pc_page = pc[OFF_W-1:PAGE_W];
    end
  endgenerate

  mri_addr_gen #(.OFF_W(OFF_W), .FLD_W(FLD_W), .PAGE_W(PAGE_W)) u_addr (
    .instr_lo   (instr_word[LO_W-1:0]),
    .pc_page    (pc_page),
    .data_field (data_field),
    .addr_use   (addr_use),
    .redirect   (req.redirect),
    .eff_addr   (eff_addr),
    .addr_valid (addr_valid),
    .ind_load   (ind_load),
    .autoinc    (autoinc_store)
  );

  assign op_class     = opc;
  assign mem_load     = req.load;
  assign mem_store    = req.store;
  assign acc_rd       = req.acc_rd;
  assign acc_wr       = req.acc_wr;
  assign link_rd      = req.link_rd;
  assign link_wr      = req.link_wr;
  assign may_redirect = req.redirect;

endmodule

// File: rtl/mri_decoder_chk.sv
module mri_decoder_chk #(
  parameter int OFF_W  = 12,
  parameter int FLD_W  = 3,
  localparam int ADDR_W = FLD_W + OFF_W,
  localparam int BUF_W  = 2 * FLD_W
) (
  input logic [OFF_W-1:0]  instr_word,
  input logic [ADDR_W-1:0] pc,
  input logic [BUF_W-1:0]  field_buf,
  input logic              mem_load,
  input logic              mem_store,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic              link_rd,
  input logic              link_wr,
  input logic              may_redirect,
  input logic              ind_load,
  input logic              autoinc_store,
  input logic              unimpl,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [ADDR_W-1:0] next_pc
);

  logic known;
  assign known = !$isunknown({instr_word, pc, field_buf});

  always_comb begin
    if (known) begin
      // R3
      unimpl_quiet_chk: assert (!unimpl || !(mem_load | mem_store | acc_rd | acc_wr |
                                  link_rd | link_wr | may_redirect | addr_valid))
        else $error("unimplemented opcode raised a request");
      // R9
      autoinc_scope_chk: assert (!autoinc_store || (ind_load && !may_redirect))
        else $error("increment request outside indirect non-redirect reference");
      // R8
      ind_needs_addr_chk: assert (!ind_load || addr_valid)
        else $error("pointer fetch without formed address");
      // R4
      field_hold_chk: assert (next_pc[ADDR_W-1:OFF_W] == pc[ADDR_W-1:OFF_W])
        else $error("successor left its field");
      // R4
      step_one_chk: assert (OFF_W'(next_pc[OFF_W-1:0] - pc[OFF_W-1:0]) == OFF_W'(1))
        else $error("successor offset did not advance by one");
      // R6
      data_field_chk: assert (!addr_valid || eff_addr[ADDR_W-1:OFF_W] == field_buf[BUF_W-1:FLD_W])
        else $error("formed address lacks the data field");
      // R7
      valid_excl_chk: assert (addr_valid != unimpl)
        else $error("address validity and unimplemented flag disagree");
    end
  end

endmodule

bind mri_decoder mri_decoder_chk #(.OFF_W(OFF_W), .FLD_W(FLD_W)) u_chk (
  .instr_word    (instr_word),
  .pc            (pc),
  .field_buf     (field_buf),
  .mem_load      (mem_load),
  .mem_store     (mem_store),
  .acc_rd        (acc_rd),
  .acc_wr        (acc_wr),
  .link_rd       (link_rd),
  .link_wr       (link_wr),
  .may_redirect  (may_redirect),
  .ind_load      (ind_load),
  .autoinc_store (autoinc_store),
  .unimpl        (unimpl),
  .addr_valid    (addr_valid),
  .eff_addr      (eff_addr),
  .next_pc       (next_pc)
);

// File: tb/mri_decoder_test.sv
module mri_decoder_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [11:0] instr_word;
  logic [14:0] pc;
  logic [5:0]  field_buf;
  logic [2:0]  op_class;
  logic mem_load, mem_store, acc_rd, acc_wr, link_rd, link_wr;
  logic may_redirect, ind_load, autoinc_store, unimpl, addr_valid;
  logic [14:0] eff_addr, next_pc;
  logic [2:0]  inst_field;

  mri_decoder uut (
    .instr_word(instr_word), .pc(pc), .field_buf(field_buf),
    .op_class(op_class), .mem_load(mem_load), .mem_store(mem_store),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .link_rd(link_rd), .link_wr(link_wr),
    .may_redirect(may_redirect), .ind_load(ind_load),
    .autoinc_store(autoinc_store), .unimpl(unimpl), .addr_valid(addr_valid),
    .eff_addr(eff_addr), .next_pc(next_pc), .inst_field(inst_field)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%o exp=%o", req, what, act, exp);
    end
  endtask

  // {load, store, acc_rd, acc_wr, link_rd, link_wr, redirect}
  function automatic int exp_req(input int op);
    case (op)
      0: return 7'b1011000;
      1: return 7'b1011110;
      2: return 7'b1100001;
      3: return 7'b0111000;
      4: return 7'b0100001;
      5: return 7'b0000001;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(input int iw, input int p, input int fb);
    int page;
    page = ((iw / 128) % 2 == 1) ? ((p % 4096) / 128) * 128 : 0;
    return (fb / 8) * 4096 + page + (iw % 128);
  endfunction

  function automatic int exp_next(input int p);
    return (p / 4096) * 4096 + ((p % 4096) + 1) % 4096;
  endfunction

  task automatic apply(input int iw, input int p, input int fb);
    int op, used, ind, ai;
    @(negedge clk);
    instr_word = 12'(iw);
    pc = 15'(p);
    field_buf = 6'(fb);
    #3;
    op = iw / 512;
    used = (op < 6) ? 1 : 0;
    ind = used * ((iw / 256) % 2);
    ai = (ind == 1 && (op == 0 || op == 1 || op == 3) && ((iw % 128) / 8) == 1) ? 1 : 0;
    chk("R1", "op_class", int'(op_class), op);
    chk("R2", "requests", int'({mem_load, mem_store, acc_rd, acc_wr, link_rd, link_wr, may_redirect}),
        exp_req(op));
    chk("R3", "unimpl", int'(unimpl), 1 - used);
    chk("R4", "next_pc", int'(next_pc), exp_next(p));
    chk("R7", "addr_valid", int'(addr_valid), used);
    if (used == 1)
      chk("R5_R6", "eff_addr", int'(eff_addr), exp_addr(iw, p, fb));
    else
      chk("R3", "eff_addr", int'(eff_addr), 0);
    chk("R8", "ind_load", int'(ind_load), ind);
    chk("R9", "autoinc_store", int'(autoinc_store), ai);
    chk("R10", "inst_field", int'(inst_field), fb % 8);
  endtask

  initial begin
    instr_word = '0;
    pc = '0;
    field_buf = '0;
    void'($urandom(32'd4242));
    #3;
    // reset-free block: all-zero inputs decode as direct AND of location 0
    chk("R1", "op at zero", int'(op_class), 0);
    chk("R4", "next at zero", int'(next_pc), 1);
    // R4 offset wrap keeps field
    apply('o0000, 'o77777, 'o00);
    // R5 current page from last word of a page, not from the successor
    apply('o1377, 'o30177, 'o25);
    apply('o1377, 'o47777, 'o70);
    apply('o1077, 'o47777, 'o70);
    // R9 window edges and exclusions
    apply('o0410, 'o00100, 'o11);
    apply('o0417, 'o00100, 'o11);
    apply('o0407, 'o00100, 'o11);
    apply('o0420, 'o00100, 'o11);
    apply('o3610, 'o02200, 'o37);
    apply('o1010, 'o00100, 'o11);
    apply('o2410, 'o00100, 'o11);
    apply('o4410, 'o00100, 'o11);
    apply('o5417, 'o00100, 'o11);
    // R3 unimplemented groups
    apply('o6000, 'o12345, 'o77);
    apply('o7777, 'o12345, 'o77);
    // R2 each opcode directly
    for (int op = 0; op < 8; op++) apply(op * 512 + 'o0123, 'o05000, 'o52);
    for (int n = 0; n < 3000; n++)
      apply(int'($urandom % 4096), int'($urandom % 32768), int'($urandom % 64));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule